// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a clocked Moore state machine that decides when to release one item from a vending mechanism. A coin sensor outside the block gives a one-cycle pulse on a nickel line or a dime line for each accepted coin. The block adds up the credit and asserts a single release output once at least 15 cents has been paid. It never returns change. If a dime brings the total past the price, the extra 5 cents is lost.

The credit is stored in 5-cent units. The price, the value of each coin and the way the release output is produced are parameters. The default build has four credit states for 0, 5, 10 and 15 cents, encoded 00, 01, 10 and 11.

Once the full price is reached, the state holds and ignores all further coins. The release output stays high until a synchronous reset returns the machine to the empty state.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the credit goes to 0 cents (state 00) and `release_o` reads low in the following cycle.
- R2: A nickel pulse (`coin_nickel`=1, `coin_dime`=0) sampled at a rising edge adds 5 cents, one step through the states 00→01→10→11.
- R3: A dime pulse adds 10 cents. A dime from 10 cents (state 10) moves to 15 cents (state 11), so the overpayment is absorbed without change.
- R4: In a cycle with neither coin line high, the credit state does not change, so idle gaps between coins have no effect on the total.
- R5: `release_o` is a Moore output, high exactly when the credit state is 15 cents (11). It rises in the cycle right after the edge that samples the coin completing the price.
- R6: In the 15-cent state, nickel and dime pulses are ignored. `release_o` stays high until reset.
- R7: Both coin lines high in the same cycle are handled like a single dime (+10 cents).
- R8: A reset taken in the 15-cent state drops `release_o` and restarts the credit at 0 cents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel | input | 1 | One-cycle pulse: a 5-cent coin was accepted |
| coin_dime | input | 1 | One-cycle pulse: a 10-cent coin was accepted |
| release_o | output | 1 | Release the item; high while 15 cents is held |

## Verification
The bench runs every coin order that reaches the price: three nickels, nickel then dime, dime then nickel, two dimes, and two nickels then a dime.

It checks that `release_o` stays low after each coin that falls short and rises exactly one cycle after the final coin. This separates a wrong step size or a wrong order of states from correct accumulation. The two-dime case proves that overpayment ends in the same state.

Separate tests cover the following:
- idle gaps between coins, which expose a state that drifts without input;
- coins arriving after release, which expose a missing saturation hold;
- a double pulse, which must count as a dime;
- a reset from the release state followed by a fresh payment, which shows that reset clears the credit fully.

// File: rtl/vend_pkg.sv
package vend_pkg;

   // Selects how the release output is produced from the credit state.
   typedef enum logic {
      REL_DECODE   = 1'b0,  // combinational decode of the state register
      REL_REGISTER = 1'b1   // separate flop loaded from next-state compare
   } rel_style_e;

   // Number of bits needed to hold credit values 0..max_units.
   function automatic int unsigned credit_bits(input int unsigned max_units);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_units) w++;
      return w;
   endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode #(
   parameter int unsigned STEP_W       = 3,
   parameter int unsigned NICKEL_UNITS = 1,
   parameter int unsigned DIME_UNITS   = 2
) (
   input  logic              coin_nickel,
   input  logic              coin_dime,
   output logic [STEP_W-1:0] step
);
   localparam logic [STEP_W-1:0] NICKEL_STEP = STEP_W'(NICKEL_UNITS);
   localparam logic [STEP_W-1:0] DIME_STEP   = STEP_W'(DIME_UNITS);

   // The dime line wins, so a double pulse counts as a dime.
   always_comb begin
      if (coin_dime)        step = DIME_STEP;
      else if (coin_nickel) step = NICKEL_STEP;
      else                  step = '0;
   end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next #(
   parameter int unsigned CREDIT_W    = 2,
   parameter int unsigned STEP_W      = 3,
   parameter int unsigned PRICE_UNITS = 3
) (
   input  logic [CREDIT_W-1:0] credit_q,
   input  logic [STEP_W-1:0]   step,
   output logic [CREDIT_W-1:0] credit_d,
   output logic                paid_d
);
   localparam int unsigned SUM_W = (CREDIT_W > STEP_W ? CREDIT_W : STEP_W) + 1;
   localparam logic [SUM_W-1:0]    PRICE_S = SUM_W'(PRICE_UNITS);
   localparam logic [CREDIT_W-1:0] PRICE_C = CREDIT_W'(PRICE_UNITS);

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum = SUM_W'(credit_q) + SUM_W'(step);
      if (credit_q == PRICE_C)  credit_d = PRICE_C;          // saturated: coins ignored
      else if (sum >= PRICE_S)  credit_d = PRICE_C;          // overpayment absorbed
      else                      credit_d = sum[CREDIT_W-1:0];
      paid_d = (credit_d == PRICE_C);
   end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg #(
   parameter int unsigned        W         = 2,
   parameter logic [W-1:0]       RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= RESET_VAL;
      else     q <= d;
   end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
   import vend_pkg::*;
#(
   parameter int unsigned PRICE_UNITS  = 3,
   parameter int unsigned NICKEL_UNITS = 1,
   parameter int unsigned DIME_UNITS   = 2,
   parameter rel_style_e  REL_STYLE    = REL_DECODE
) (
   input  logic clk,
   input  logic rst,
   input  logic coin_nickel,
   input  logic coin_dime,
   output logic release_o
);
   localparam int unsigned CREDIT_W = credit_bits(PRICE_UNITS);
   localparam int unsigned STEP_W   = credit_bits(DIME_UNITS > NICKEL_UNITS ? DIME_UNITS : NICKEL_UNITS);
   localparam logic [CREDIT_W-1:0] PRICE_C = CREDIT_W'(PRICE_UNITS);

   generate
      if (PRICE_UNITS < 1)
         $error("vend_ctrl: PRICE_UNITS must be at least 1");
      if (NICKEL_UNITS < 1 || DIME_UNITS < 1)
         $error("vend_ctrl: coin values must be nonzero");
   endgenerate

   logic [STEP_W-1:0]   step;
   logic [CREDIT_W-1:0] credit_d;
   logic [CREDIT_W-1:0] credit_q;
   logic                paid_d;

   vend_coin_decode #(
      .STEP_W(STEP_W), .NICKEL_UNITS(NICKEL_UNITS), .DIME_UNITS(DIME_UNITS)
   ) u_decode (
      .coin_nickel(coin_nickel), .coin_dime(coin_dime), .step(step)
   );

   vend_credit_next #(
      .CREDIT_W(CREDIT_W), .STEP_W(STEP_W), .PRICE_UNITS(PRICE_UNITS)
   ) u_next (
      .credit_q(credit_q), .step(step), .credit_d(credit_d), .paid_d(paid_d)
   );

   vend_state_reg #(
      .W(CREDIT_W), .RESET_VAL('0)
   ) u_credit (
      .clk(clk), .rst(rst), .d(credit_d), .q(credit_q)
   );

   generate
      if (REL_STYLE == REL_REGISTER) begin : g_rel_reg
         logic rel_q;
         vend_state_reg #(.W(1), .RESET_VAL(1'b0)) u_rel (
            .clk(clk), .rst(rst), .d(paid_d), .q(rel_q)
         );
         assign release_o = rel_q;
      end else begin : g_rel_dec
         logic unused_paid;
         assign unused_paid = paid_d;
         assign release_o   = (credit_q == PRICE_C);
      end
   endgenerate
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
   parameter int unsigned CREDIT_W     = 2,
   parameter int unsigned PRICE_UNITS  = 3,
   parameter int unsigned NICKEL_UNITS = 1,
   parameter int unsigned DIME_UNITS   = 2
) (
   input logic                clk,
   input logic                rst,
   input logic                coin_nickel,
   input logic                coin_dime,
   input logic                release_o,
   input logic [CREDIT_W-1:0] credit_q
);
   localparam logic [CREDIT_W-1:0] PRICE_C = CREDIT_W'(PRICE_UNITS);
   localparam logic [CREDIT_W-1:0] AFTER_N =
      CREDIT_W'(NICKEL_UNITS >= PRICE_UNITS ? PRICE_UNITS : NICKEL_UNITS);
   localparam logic [CREDIT_W-1:0] AFTER_D =
      CREDIT_W'(DIME_UNITS >= PRICE_UNITS ? PRICE_UNITS : DIME_UNITS);

   // R1 / R8: reset empties the credit and drops release
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (credit_q == '0 && !release_o));

   // R2: nickel from empty
   a_r2_nickel_step: assert property (@(posedge clk) disable iff (rst)
      (credit_q == '0 && coin_nickel && !coin_dime) |=> credit_q == AFTER_N);

   // R3: dime from empty
   a_r3_dime_step: assert property (@(posedge clk) disable iff (rst)
      (credit_q == '0 && coin_dime && !coin_nickel) |=> credit_q == AFTER_D);

   // R4: no coin, no change
   a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!coin_nickel && !coin_dime) |=> $stable(credit_q));

   // R5: release only follows a coin
   a_r5_rise_after_coin: assert property (@(posedge clk) disable iff (rst)
      (!release_o && !coin_nickel && !coin_dime) |=> !release_o);

   // R6: saturated state holds
   a_r6_saturate_hold: assert property (@(posedge clk) disable iff (rst)
      (credit_q == PRICE_C) |=> (credit_q == PRICE_C && release_o));

   // R7: double pulse counts as a dime
   a_r7_double_is_dime: assert property (@(posedge clk) disable iff (rst)
      (credit_q == '0 && coin_nickel && coin_dime) |=> credit_q == AFTER_D);
endmodule

bind vend_ctrl vend_ctrl_chk #(
   .CREDIT_W(CREDIT_W), .PRICE_UNITS(PRICE_UNITS),
   .NICKEL_UNITS(NICKEL_UNITS), .DIME_UNITS(DIME_UNITS)
) u_chk (
   .clk(clk), .rst(rst), .coin_nickel(coin_nickel), .coin_dime(coin_dime),
   .release_o(release_o), .credit_q(credit_q)
);

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic coin_nickel = 1'b0;
   logic coin_dime = 1'b0;
   logic release_o;
   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   vend_ctrl dut (
      .clk(clk), .rst(rst), .coin_nickel(coin_nickel),
      .coin_dime(coin_dime), .release_o(release_o)
   );

   task automatic chk(input logic exp, input string req, input string what);
      n_checks++;
      if (release_o !== exp) begin
         n_errors++;
         $display("FAIL %s %s: release_o actual=%b expected=%b", req, what, release_o, exp);
      end
   endtask

   // Present one coin for exactly one rising edge; return at the next falling edge.
   task automatic put(input logic n, input logic d);
      @(negedge clk);
      coin_nickel = n;
      coin_dime   = d;
      @(negedge clk);
      coin_nickel = 1'b0;
      coin_dime   = 1'b0;
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_three_nickels();
      do_reset();
      put(1, 0); chk(0, "R2", "3N after 1st");
      put(1, 0); chk(0, "R2", "3N after 2nd");
      put(1, 0); chk(1, "R5", "3N after 3rd");
   endtask

   task automatic t_nickel_dime();
      do_reset();
      put(1, 0); chk(0, "R2", "N,D after N");
      put(0, 1); chk(1, "R3", "N,D after D");
   endtask

   task automatic t_dime_nickel();
      do_reset();
      put(0, 1); chk(0, "R3", "D,N after D");
      put(1, 0); chk(1, "R5", "D,N after N");
   endtask

   task automatic t_two_dimes();
      do_reset();
      put(0, 1); chk(0, "R3", "D,D after 1st");
      put(0, 1); chk(1, "R3", "D,D overpay");
   endtask

   task automatic t_two_nickels_dime();
      do_reset();
      put(1, 0); put(1, 0); chk(0, "R2", "N,N,D before D");
      put(0, 1); chk(1, "R3", "N,N,D from 10c");
   endtask

   task automatic t_idle_gaps();
      do_reset();
      put(1, 0); idle(4); chk(0, "R4", "gap after 5c");
      put(1, 0); idle(3); chk(0, "R4", "gap after 10c");
      put(1, 0); chk(1, "R4", "total kept across gaps");
   endtask

   task automatic t_saturate_and_reset();
      do_reset();
      put(0, 1); put(0, 1); chk(1, "R6", "reach 15c");
      put(1, 0); chk(1, "R6", "nickel ignored");
      put(0, 1); idle(3); chk(1, "R6", "dime ignored, held");
      do_reset(); chk(0, "R8", "reset from 15c");
      put(0, 1); chk(0, "R8", "restart from 0c");
      put(1, 0); chk(1, "R8", "fresh payment");
   endtask

   task automatic t_double_pulse();
      do_reset();
      put(1, 1); chk(0, "R7", "double = 10c");
      put(1, 0); chk(1, "R7", "double then nickel");
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      rst = 1'b1;
      idle(2);
      chk(0, "R1", "in reset");
      rst = 1'b0;
      @(negedge clk);
      chk(0, "R1", "after reset");
      t_three_nickels();
      t_nickel_dime();
      t_dime_nickel();
      t_two_dimes();
      t_two_nickels_dime();
      t_idle_gaps();
      t_saturate_and_reset();
      t_double_pulse();
      finish_run();
   end

   initial begin
      #100000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end
endmodule